// File: doc/BRIEF.md
# ULPI PHY Control Register Bank

This block holds the two 8-bit control registers that the PHY side of a ULPI transceiver exposes to its link: an interface control register and an OTG control register. An already decoded register access (address, write data, write strobe, read strobe) arrives each cycle. Each register answers at three consecutive addresses: the first loads the data, the second ORs it in, the third clears every bit that is 1 in the data. Reads are accepted at all three addresses.

The register bits drive the rest of the PHY as plain control pins. Two serial-mode bits are cleared by the PHY itself when the matching serial mode ends. A clock keep-alive output is qualified by the suspend input. A fault indicator output passes or inverts the external fault input.

Top module: `phy_ctrl_regbank`

## Requirements
- R1: After reset the interface control register reads 00h and the OTG control register reads 06h, so `dm_pd_en` and `dp_pd_en` are 1 and every other control output is 0.
- R2: A write to 07h loads the interface register and a write to 0Ah loads the OTG register. Interface bit positions: 7 `iface_guard_off`, 6 `indicator_qual_bypass`, 5 `fault_invert`, 3 keep-alive request, 1 `serial3_mode`, 0 `serial6_mode`. OTG bit positions: 7 `ext_vbus_sel`, 6 `vbus_ext_drive`, 5 `vbus_drive`, 4 `vbus_charge`, 3 `vbus_discharge`, 2 `dm_pd_en`, 1 `dp_pd_en`. Outside of writes the OTG outputs hold.
- R3: A write to 08h (interface) or 0Bh (OTG) ORs the write data into the register.
- R4: A write to 09h (interface) or 0Ch (OTG) clears each register bit whose write-data bit is 1 and leaves the others.
- R5: A read strobe at any of 07h–09h returns the interface register and at 0Ah–0Ch returns the OTG register on `acc_rdata` one cycle later. `acc_rdata` holds when no read is strobed.
- R6: Reserved bits (interface bits 4 and 2, OTG bit 0) always read 0, whatever is loaded, set or cleared.
- R7: A pulse on `exit_3pin` clears interface bit 1 and a pulse on `exit_6pin` clears interface bit 0. When such a pulse meets a write that sets the same bit in the same cycle, the bit ends up 0.
- R8: `clk_keep_alive` is 1 only when interface bit 3 is 1, `suspend_n` is 1 and at least one serial-mode bit (1 or 0) is 1.
- R9: `fault_out` equals `fault_in` while interface bit 5 is 0 and equals its inverse while bit 5 is 1.
- R10: A read at an address outside 07h–0Ch returns 00h. A write there changes no register.
- R11: A set followed by a clear with the same mask, where the mask bits were 0 before, restores the register's earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 6 | Decoded register address |
| acc_wdata | input | 8 | Write data |
| acc_we | input | 1 | Write strobe, one access per cycle |
| acc_re | input | 1 | Read strobe |
| acc_rdata | output | 8 | Read data, valid the cycle after `acc_re` |
| suspend_n | input | 1 | Low while the PHY is suspended |
| exit_3pin | input | 1 | Pulse: 3-pin serial mode has ended |
| exit_6pin | input | 1 | Pulse: 6-pin serial mode has ended |
| fault_in | input | 1 | External fault input |
| fault_out | output | 1 | Fault indicator, optionally inverted |
| iface_guard_off | output | 1 | Disables the interface protection circuit |
| indicator_qual_bypass | output | 1 | Fault indicator is not qualified by the VBUS comparator |
| fault_invert | output | 1 | Fault inversion enable |
| clk_keep_alive | output | 1 | Keeps the clock powered in serial modes |
| serial3_mode | output | 1 | 3-pin serial mode enable |
| serial6_mode | output | 1 | 6-pin serial mode enable |
| ext_vbus_sel | output | 1 | Use external VBUS indicator |
| vbus_ext_drive | output | 1 | Drive VBUS through an external supply |
| vbus_drive | output | 1 | Drive VBUS |
| vbus_charge | output | 1 | Charge VBUS |
| vbus_discharge | output | 1 | Discharge VBUS |
| dm_pd_en | output | 1 | D- pull-down enable |
| dp_pd_en | output | 1 | D+ pull-down enable |

## Verification
The case where two functions meet in one cycle is the PHY's own clearing of a serial-mode bit arriving in the same cycle as a register write that sets that bit. The bench raises `exit_6pin` in the same cycle as a load of 03h to 07h. The readback must then show 02h: the write took effect on bit 1 and the hardware clear took effect on bit 0. A separate run with a lone `exit_3pin` pulse confirms that the clear works alone and leaves the other bits as they were.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 2;

  // alias offsets from a register's base; order is behaviour
  localparam logic [ADDR_W-1:0] OFF_LOAD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_LAST = OFF_CLR;

  localparam logic [ADDR_W-1:0] IFC_BASE = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] OTG_BASE = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] IFC_LAST = IFC_BASE + OFF_LAST;
  localparam logic [ADDR_W-1:0] OTG_LAST = OTG_BASE + OFF_LAST;

  localparam logic [DATA_W-1:0] IFC_RST  = 8'h00;
  localparam logic [DATA_W-1:0] OTG_RST  = 8'h06;
  localparam logic [DATA_W-1:0] IFC_RSVD = 8'h14;
  localparam logic [DATA_W-1:0] OTG_RSVD = 8'h01;

  // interface register bit positions
  localparam int IB_GUARD_OFF = 7;
  localparam int IB_QUAL_BYP  = 6;
  localparam int IB_FLT_INV   = 5;
  localparam int IB_KEEPALIVE = 3;
  localparam int IB_SER3      = 1;
  localparam int IB_SER6      = 0;

  // OTG register bit positions
  localparam int OB_EXT_SEL  = 7;
  localparam int OB_EXT_DRV  = 6;
  localparam int OB_DRV      = 5;
  localparam int OB_CHRG     = 4;
  localparam int OB_DISCHRG  = 3;
  localparam int OB_DM_PD    = 2;
  localparam int OB_DP_PD    = 1;

  localparam int REG_IFC = 0;
  localparam int REG_OTG = 1;
endpackage

// File: rtl/phy_alias_decode.sv
module phy_alias_decode
  import phy_ctrl_pkg::*;
#(
  parameter int N = NUM_REGS,
  parameter logic [N*ADDR_W-1:0] BASES = {OTG_BASE, IFC_BASE}
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic [N-1:0]      hit,
  output logic [N-1:0]      do_load,
  output logic [N-1:0]      do_set,
  output logic [N-1:0]      do_clr
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = BASES[g*ADDR_W +: ADDR_W];
    logic [ADDR_W-1:0] off;
    assign off        = addr - BASE;
    assign hit[g]     = (addr >= BASE) && (off <= OFF_LAST);
    assign do_load[g] = we && hit[g] && (off == OFF_LOAD);
    assign do_set[g]  = we && hit[g] && (off == OFF_SET);
    assign do_clr[g]  = we && hit[g] && (off == OFF_CLR);
  end
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg #(
  parameter int         W         = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] RSVD    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         do_load,
  input  logic         do_set,
  input  logic         do_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] sw_next;

  always_comb begin
    if (do_load)     sw_next = wdata;
    else if (do_set) sw_next = q | wdata;
    else if (do_clr) sw_next = q & ~wdata;
    else             sw_next = q;
  end

  // hardware clear applied last so it overrides any software update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= sw_next & ~RSVD & ~hw_clr;
  end
endmodule

// File: rtl/phy_side_outputs.sv
module phy_side_outputs (
  input  logic fault_in,
  input  logic invert,
  input  logic keep_req,
  input  logic suspend_n,
  input  logic ser3,
  input  logic ser6,
  output logic fault_out,
  output logic clk_keep_alive
);
  assign fault_out      = invert ? ~fault_in : fault_in;
  assign clk_keep_alive = keep_req & suspend_n & (ser3 | ser6);
endmodule

// File: rtl/phy_ctrl_regbank.sv
module phy_ctrl_regbank
  import phy_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_we,
  input  logic              acc_re,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              suspend_n,
  input  logic              exit_3pin,
  input  logic              exit_6pin,
  input  logic              fault_in,
  output logic              fault_out,
  output logic              iface_guard_off,
  output logic              indicator_qual_bypass,
  output logic              fault_invert,
  output logic              clk_keep_alive,
  output logic              serial3_mode,
  output logic              serial6_mode,
  output logic              ext_vbus_sel,
  output logic              vbus_ext_drive,
  output logic              vbus_drive,
  output logic              vbus_charge,
  output logic              vbus_discharge,
  output logic              dm_pd_en,
  output logic              dp_pd_en
);
  localparam logic [NUM_REGS*DATA_W-1:0] RST_VALS  = {OTG_RST, IFC_RST};
  localparam logic [NUM_REGS*DATA_W-1:0] RSVD_MSKS = {OTG_RSVD, IFC_RSVD};

  logic [NUM_REGS-1:0] hit, do_load, do_set, do_clr;
  logic [DATA_W-1:0]   regq   [NUM_REGS];
  logic [DATA_W-1:0]   hwclr  [NUM_REGS];
  logic [DATA_W-1:0]   rd_mux;

  phy_alias_decode #(
    .N     (NUM_REGS),
    .BASES ({OTG_BASE, IFC_BASE})
  ) dec_i (
    .addr    (acc_addr),
    .we      (acc_we),
    .hit     (hit),
    .do_load (do_load),
    .do_set  (do_set),
    .do_clr  (do_clr)
  );

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) hwclr[i] = '0;
    hwclr[REG_IFC][IB_SER3] = exit_3pin;
    hwclr[REG_IFC][IB_SER6] = exit_6pin;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    phy_ctrl_reg #(
      .W       (DATA_W),
      .RST_VAL (RST_VALS[g*DATA_W +: DATA_W]),
      .RSVD    (RSVD_MSKS[g*DATA_W +: DATA_W])
    ) reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_load (do_load[g]),
      .do_set  (do_set[g]),
      .do_clr  (do_clr[g]),
      .wdata   (acc_wdata),
      .hw_clr  (hwclr[g]),
      .q       (regq[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit[i]) rd_mux = rd_mux | regq[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_rdata <= '0;
    else if (acc_re) acc_rdata <= rd_mux;
  end

  assign iface_guard_off       = regq[REG_IFC][IB_GUARD_OFF];
  assign indicator_qual_bypass = regq[REG_IFC][IB_QUAL_BYP];
  assign fault_invert          = regq[REG_IFC][IB_FLT_INV];
  assign serial3_mode          = regq[REG_IFC][IB_SER3];
  assign serial6_mode          = regq[REG_IFC][IB_SER6];

  assign ext_vbus_sel   = regq[REG_OTG][OB_EXT_SEL];
  assign vbus_ext_drive = regq[REG_OTG][OB_EXT_DRV];
  assign vbus_drive     = regq[REG_OTG][OB_DRV];
  assign vbus_charge    = regq[REG_OTG][OB_CHRG];
  assign vbus_discharge = regq[REG_OTG][OB_DISCHRG];
  assign dm_pd_en       = regq[REG_OTG][OB_DM_PD];
  assign dp_pd_en       = regq[REG_OTG][OB_DP_PD];

  phy_side_outputs side_i (
    .fault_in       (fault_in),
    .invert         (regq[REG_IFC][IB_FLT_INV]),
    .keep_req       (regq[REG_IFC][IB_KEEPALIVE]),
    .suspend_n      (suspend_n),
    .ser3           (regq[REG_IFC][IB_SER3]),
    .ser6           (regq[REG_IFC][IB_SER6]),
    .fault_out      (fault_out),
    .clk_keep_alive (clk_keep_alive)
  );
endmodule

// File: rtl/phy_ctrl_regbank_chk.sv
module phy_ctrl_regbank_chk
  import phy_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_we,
  input logic              acc_re,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              suspend_n,
  input logic              exit_3pin,
  input logic              exit_6pin,
  input logic              fault_in,
  input logic              fault_out,
  input logic              fault_invert,
  input logic              clk_keep_alive,
  input logic              serial3_mode,
  input logic              serial6_mode,
  input logic              ext_vbus_sel,
  input logic              vbus_ext_drive,
  input logic              vbus_drive,
  input logic              vbus_charge,
  input logic              vbus_discharge,
  input logic              dm_pd_en,
  input logic              dp_pd_en
);
  logic ifc_hit, otg_hit;
  logic [6:0] otg_pins;
  assign ifc_hit  = (acc_addr >= IFC_BASE) && (acc_addr <= IFC_LAST);
  assign otg_hit  = (acc_addr >= OTG_BASE) && (acc_addr <= OTG_LAST);
  assign otg_pins = {ext_vbus_sel, vbus_ext_drive, vbus_drive, vbus_charge,
                     vbus_discharge, dm_pd_en, dp_pd_en};

  AST_IFC_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re && ifc_hit) |=> ((acc_rdata & IFC_RSVD) == '0)); // R6
  AST_OTG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re && otg_hit) |=> ((acc_rdata & OTG_RSVD) == '0)); // R6
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re && !ifc_hit && !otg_hit) |=> (acc_rdata == '0)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_re |=> $stable(acc_rdata)); // R5
  AST_EXIT3_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exit_3pin |=> !serial3_mode); // R7
  AST_EXIT6_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exit_6pin |=> !serial6_mode); // R7
  AST_KEEPALIVE_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend_n || (!serial3_mode && !serial6_mode)) |-> !clk_keep_alive); // R8
  AST_FAULT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_invert |-> (fault_out == fault_in)); // R9
  AST_FAULT_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_invert |-> (fault_out != fault_in)); // R9
  AST_OTG_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_we |=> $stable(otg_pins)); // R2
endmodule

bind phy_ctrl_regbank phy_ctrl_regbank_chk chk_i (.*);

// File: tb/phy_ctrl_regbank_tb_top.sv
module phy_ctrl_regbank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic       acc_we = 1'b0, acc_re = 1'b0;
  logic [7:0] acc_rdata;
  logic       suspend_n = 1'b1, exit_3pin = 1'b0, exit_6pin = 1'b0;
  logic       fault_in = 1'b0, fault_out;
  logic       iface_guard_off, indicator_qual_bypass, fault_invert, clk_keep_alive;
  logic       serial3_mode, serial6_mode;
  logic       ext_vbus_sel, vbus_ext_drive, vbus_drive, vbus_charge;
  logic       vbus_discharge, dm_pd_en, dp_pd_en;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #5 clk = ~clk;

  phy_ctrl_regbank dut_i (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // driver
  task automatic acc_write(logic [5:0] a, logic [7:0] d, logic e3 = 0, logic e6 = 0);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; acc_we = 1'b1; exit_3pin = e3; exit_6pin = e6;
    @(negedge clk);
    acc_we = 1'b0; exit_3pin = 1'b0; exit_6pin = 1'b0;
  endtask

  task automatic acc_read(logic [5:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    acc_addr = a; acc_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    acc_re = 1'b0;
  endtask

  task automatic pulse_exit(logic e3, logic e6);
    @(negedge clk);
    exit_3pin = e3; exit_6pin = e6;
    @(negedge clk);
    exit_3pin = 1'b0; exit_6pin = 1'b0;
  endtask

  // monitor: read data appears after the capturing edge
  always @(posedge clk) rd_seen <= acc_re;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R5: unexpected read data %02h expected none", acc_rdata);
      end else begin
        check(tag_q.pop_front(), acc_rdata, exp_q.pop_front());
      end
    end
  end

  function automatic logic [7:0] ifc_pins();
    return {iface_guard_off, indicator_qual_bypass, fault_invert, 3'b000, serial3_mode, serial6_mode};
  endfunction
  function automatic logic [7:0] otg_pins();
    return {ext_vbus_sel, vbus_ext_drive, vbus_drive, vbus_charge, vbus_discharge, dm_pd_en, dp_pd_en, 1'b0};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values, R5 all aliases
    check("R1 otg pins", otg_pins(), 8'h06);
    check("R1 ifc pins", ifc_pins(), 8'h00);
    check("R1 keepalive", {7'b0, clk_keep_alive}, 8'h00);
    acc_read(6'h07, 8'h00, "R1 R5 ifc@07");
    acc_read(6'h08, 8'h00, "R1 R5 ifc@08");
    acc_read(6'h09, 8'h00, "R1 R5 ifc@09");
    acc_read(6'h0A, 8'h06, "R1 R5 otg@0A");
    acc_read(6'h0B, 8'h06, "R1 R5 otg@0B");
    acc_read(6'h0C, 8'h06, "R1 R5 otg@0C");

    // R2 load, R6 reserved bits
    acc_write(6'h07, 8'hFF);
    check("R2 ifc pins after load", ifc_pins(), 8'hE3);
    acc_read(6'h08, 8'hEB, "R2 R6 ifc load FF");
    acc_write(6'h07, 8'h00);
    acc_read(6'h09, 8'h00, "R2 ifc load 00");

    // R3 set, R4 clear
    acc_write(6'h08, 8'h22);
    acc_read(6'h07, 8'h22, "R3 ifc set 22");
    acc_write(6'h08, 8'h09);
    acc_read(6'h07, 8'h2B, "R3 ifc set 09");
    acc_write(6'h09, 8'h20);
    acc_read(6'h07, 8'h0B, "R4 ifc clr 20");

    // R8 keep-alive qualification
    check("R8 keepalive active", {7'b0, clk_keep_alive}, 8'h01);
    @(negedge clk) suspend_n = 1'b0;
    @(negedge clk);
    check("R8 keepalive suspended", {7'b0, clk_keep_alive}, 8'h00);
    suspend_n = 1'b1;
    acc_write(6'h09, 8'h03);
    check("R8 keepalive no serial mode", {7'b0, clk_keep_alive}, 8'h00);
    acc_write(6'h08, 8'h02);

    // R9 fault indicator
    @(negedge clk) fault_in = 1'b1;
    @(negedge clk);
    check("R9 fault pass", {7'b0, fault_out}, 8'h01);
    acc_write(6'h08, 8'h20);
    check("R9 fault inverted hi", {7'b0, fault_out}, 8'h00);
    @(negedge clk) fault_in = 1'b0;
    @(negedge clk);
    check("R9 fault inverted lo", {7'b0, fault_out}, 8'h01);

    // R7 hardware clears
    acc_write(6'h08, 8'h01);
    acc_read(6'h07, 8'h2B, "R7 before exit");
    pulse_exit(1'b1, 1'b0);
    check("R7 serial3 cleared", {7'b0, serial3_mode}, 8'h00);
    acc_read(6'h07, 8'h29, "R7 exit3 only bit1");
    acc_write(6'h07, 8'h03, 1'b0, 1'b1);
    acc_read(6'h07, 8'h02, "R7 exit6 beats load");

    // OTG: R2 R6 R4 R3 R11
    acc_write(6'h0A, 8'hFF);
    check("R2 otg pins after load", otg_pins(), 8'hFE);
    acc_read(6'h0B, 8'hFE, "R2 R6 otg load FF");
    acc_write(6'h0C, 8'h06);
    acc_read(6'h0A, 8'hF8, "R4 otg clr 06");
    acc_write(6'h0B, 8'h01);
    acc_read(6'h0C, 8'hF8, "R6 otg set rsvd");
    acc_write(6'h0B, 8'h06);
    acc_read(6'h0A, 8'hFE, "R3 R11 otg set 06");
    acc_write(6'h0C, 8'h06);
    acc_read(6'h0A, 8'hF8, "R11 otg restored");
    check("R11 otg pins restored", otg_pins(), 8'hF8);

    // R10 unmapped
    acc_read(6'h06, 8'h00, "R10 read 06");
    acc_read(6'h0D, 8'h00, "R10 read 0D");
    acc_read(6'h15, 8'h00, "R10 read 15");
    acc_write(6'h15, 8'hFF);
    acc_write(6'h0D, 8'hFF);
    acc_write(6'h06, 8'h00);
    acc_read(6'h07, 8'h02, "R10 ifc unchanged");
    acc_read(6'h0A, 8'hF8, "R10 otg unchanged");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R5: actual %0d reads pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule